// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is the test access port of a chip's boundary-scan logic. A tester drives a test clock, a mode-select line and a serial data input. Together they steer a sixteen-state controller through instruction and data scans. The controller holds a 3-bit instruction. It decodes that instruction into boundary modes, and it connects one data path between the serial input and the serial output. That path is a 1-bit bypass stage, a 32-bit identification register, or the chip's boundary register, which sits outside the block.

The boundary register is reached through a serial pair (`bsr_si` out, `bsr_so` in) and three strobes that mark its capture, shift and update states. The test logic works only while a compliance-enable input is high. While that input is low, the controller is held in its reset state, the serial output is not driven, and every mode and strobe output is inactive.

Top module: `tap_ctrl`

## Requirements
- R1: Asserting `trst_n` low immediately forces the controller into Test-Logic-Reset and the instruction to identify. `tdo_oe`, all three mode outputs and all three boundary strobes are then low. Release of `trst_n` takes effect after two rising `tck` edges.
- R2: The controller follows the standard sixteen-state graph on rising `tck`. Five consecutive rising edges with `tms` high reach Test-Logic-Reset from any state, and four such edges are not enough from Shift-DR.
- R3: The instruction shift stage is 3 bits. It loads 3'b001 in Capture-IR and shifts LSB first, with `tdi` entering the MSB on rising `tck`, so a scan of that capture returns 1, 0, 0 on `tdo`.
- R4: The instruction code is decoded as follows. 3'b000 and 3'b011 select boundary drive (`mode_extest`). 3'b001 selects boundary sample (`mode_sample`). 3'b010 selects identify. 3'b100 and 3'b110 select pins-off (`mode_highz`). 3'b101 and 3'b111 select bypass. A scanned code takes effect on the falling `tck` edge in Update-IR. At most one mode output is high at a time.
- R5: The bypass stage is one bit and captures 0 in Capture-DR. A data scan under it returns 0 and then the input stream delayed by one bit.
- R6: Under identify, Capture-DR loads 32'h05B0503F. That value is bit 0 set, manufacturer code 11'h01F in bits 11:1, part number 16'h5B05 in bits 27:12 and version 0 in bits 31:28. It shifts out LSB first.
- R7: Under boundary drive or boundary sample, the data path is `bsr_si` = `tdi` and `tdo` from `bsr_so`. `bsr_capture`, `bsr_shift` and `bsr_update` are high exactly in Capture-DR, Shift-DR and Update-DR. Under any other instruction they stay low.
- R8: Pins-off routes the bypass stage. `mode_highz` stays high through data scans and through every state until another instruction is updated or the controller resets.
- R9: `tdo` and `tdo_oe` change only on falling `tck`. `tdo_oe` is high only in the half cycle after a falling edge in Shift-IR or Shift-DR.
- R10: While `comp_en` is low, the controller is held in Test-Logic-Reset on each rising edge. `tdo_oe`, the mode outputs and the strobes are low at once. After `comp_en` returns high, the instruction is identify.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| tms | input | 1 | Mode select, sampled on rising tck |
| tdi | input | 1 | Serial data in |
| trst_n | input | 1 | Asynchronous active-low controller reset |
| comp_en | input | 1 | Compliance enable; test logic active when high |
| tdo | output | 1 | Serial data out, updated on falling tck |
| tdo_oe | output | 1 | Output enable for tdo |
| mode_extest | output | 1 | Boundary register drives pins |
| mode_sample | output | 1 | Boundary register samples pins |
| mode_highz | output | 1 | All pin drivers off |
| bsr_capture | output | 1 | Boundary register capture strobe |
| bsr_shift | output | 1 | Boundary register shift strobe |
| bsr_update | output | 1 | Boundary register update strobe |
| bsr_si | output | 1 | Serial input to the boundary register |
| bsr_so | input | 1 | Serial output of the boundary register |

## Verification
The assertions watch several rules on every rising edge. A run of five high `tms` edges must end in Test-Logic-Reset, and a low `comp_en` must hold that state. Capture-IR must leave 01 in the low instruction bits. The bypass and identification stages must hold their capture values after Capture-DR. The mode outputs must stay one-hot-or-none. A boundary strobe must appear only under a boundary instruction, and `tdo_oe` only in a shift state. The bench sweeps all eight instruction codes. For each one it computes the scan path length and contents, and it proves the duplicate encodings, the bit-exact identification value, the serial order and the strobe counts per scan. Persistence of pins-off, the exact five-edge reset boundary, `tdo` stability across rising edges, and the recovery after asynchronous reset or a low `comp_en` are shown only by these scenarios.

// File: rtl/tap_pkg.sv
package tap_pkg;

  typedef enum logic [3:0] {
    S_RESET,  S_IDLE,
    S_SEL_DR, S_CAP_DR, S_SH_DR, S_EX1_DR, S_PAU_DR, S_EX2_DR, S_UPD_DR,
    S_SEL_IR, S_CAP_IR, S_SH_IR, S_EX1_IR, S_PAU_IR, S_EX2_IR, S_UPD_IR
  } tap_state_t;

  typedef enum logic [2:0] {
    K_EXTEST, K_SAMPLE, K_IDCODE, K_HIGHZ, K_BYPASS
  } instr_t;

  localparam int                IR_W        = 3;
  localparam logic [IR_W-1:0]   OP_IDENTIFY = 3'b010;
  localparam logic [IR_W-1:0]   IR_CAPTURE  = 3'b001;

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import tap_pkg::*;
#(
  parameter int RESET_RUN = 5
) (
  input  logic       tck,
  input  logic       rst_n,
  input  logic       comp_en,
  input  logic       tms,
  output tap_state_t state
);

  localparam int CW = $clog2(RESET_RUN + 1);

  tap_state_t state_d;
  logic [CW-1:0] ones_q, ones_d;

  always_comb begin
    state_d = state;
    unique case (state)
      S_RESET:  state_d = tms ? S_RESET  : S_IDLE;
      S_IDLE:   state_d = tms ? S_SEL_DR : S_IDLE;
      S_SEL_DR: state_d = tms ? S_SEL_IR : S_CAP_DR;
      S_CAP_DR: state_d = tms ? S_EX1_DR : S_SH_DR;
      S_SH_DR:  state_d = tms ? S_EX1_DR : S_SH_DR;
      S_EX1_DR: state_d = tms ? S_UPD_DR : S_PAU_DR;
      S_PAU_DR: state_d = tms ? S_EX2_DR : S_PAU_DR;
      S_EX2_DR: state_d = tms ? S_UPD_DR : S_SH_DR;
      S_UPD_DR: state_d = tms ? S_SEL_DR : S_IDLE;
      S_SEL_IR: state_d = tms ? S_RESET  : S_CAP_IR;
      S_CAP_IR: state_d = tms ? S_EX1_IR : S_SH_IR;
      S_SH_IR:  state_d = tms ? S_EX1_IR : S_SH_IR;
      S_EX1_IR: state_d = tms ? S_UPD_IR : S_PAU_IR;
      S_PAU_IR: state_d = tms ? S_EX2_IR : S_PAU_IR;
      S_EX2_IR: state_d = tms ? S_UPD_IR : S_SH_IR;
      S_UPD_IR: state_d = tms ? S_SEL_DR : S_IDLE;
      default:  state_d = S_RESET;
    endcase
    if (!comp_en) state_d = S_RESET;
  end

  always_comb begin
    ones_d = '0;
    if (tms) ones_d = (ones_q == CW'(RESET_RUN)) ? ones_q : ones_q + 1'b1;
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_RESET;
      ones_q <= '0;
    end else begin
      state  <= state_d;
      ones_q <= ones_d;
    end
  end

  assert_five_ones_R2: assert property (@(posedge tck) disable iff (!rst_n)
    (ones_q == CW'(RESET_RUN)) |-> (state == S_RESET));

  assert_comp_hold_R10: assert property (@(posedge tck) disable iff (!rst_n)
    !comp_en |=> (state == S_RESET));

endmodule

// File: rtl/tap_ir.sv
module tap_ir
  import tap_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  tap_state_t state,
  input  logic       tdi,
  output logic       ir_so,
  output instr_t     instr
);

  logic [IR_W-1:0] sh_q, sh_d;
  logic [IR_W-1:0] cur_q, cur_d;

  always_comb begin
    sh_d = sh_q;
    if (state == S_CAP_IR)     sh_d = IR_CAPTURE;
    else if (state == S_SH_IR) sh_d = {tdi, sh_q[IR_W-1:1]};
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) sh_q <= IR_CAPTURE;
    else        sh_q <= sh_d;
  end

  always_comb begin
    cur_d = cur_q;
    if (state == S_RESET)       cur_d = OP_IDENTIFY;
    else if (state == S_UPD_IR) cur_d = sh_q;
  end

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) cur_q <= OP_IDENTIFY;
    else        cur_q <= cur_d;
  end

  always_comb begin
    unique case (cur_q)
      3'b000, 3'b011: instr = K_EXTEST;
      3'b001:         instr = K_SAMPLE;
      3'b010:         instr = K_IDCODE;
      3'b100, 3'b110: instr = K_HIGHZ;
      default:        instr = K_BYPASS;
    endcase
  end

  assign ir_so = sh_q[0];

  assert_ir_capture_R3: assert property (@(posedge tck) disable iff (!rst_n)
    (state == S_CAP_IR) |=> (sh_q[1:0] == 2'b01));

endmodule

// File: rtl/tap_dr.sv
module tap_dr
  import tap_pkg::*;
#(
  parameter int          ID_W     = 32,
  parameter logic [31:0] ID_VALUE = 32'h05B0503F
) (
  input  logic       tck,
  input  logic       rst_n,
  input  tap_state_t state,
  input  instr_t     instr,
  input  logic       tdi,
  input  logic       bsr_so,
  output logic       bsr_sel,
  output logic       dr_so
);

  localparam logic [ID_W-1:0] ID_INIT = ID_W'(ID_VALUE);

  logic            byp_q, byp_d;
  logic [ID_W-1:0] id_q, id_d;
  logic            id_sel, byp_sel;

  assign bsr_sel = (instr == K_EXTEST) || (instr == K_SAMPLE);
  assign id_sel  = (instr == K_IDCODE);
  assign byp_sel = !bsr_sel && !id_sel;

  always_comb begin
    byp_d = byp_q;
    if (byp_sel && state == S_CAP_DR)     byp_d = 1'b0;
    else if (byp_sel && state == S_SH_DR) byp_d = tdi;
  end

  always_comb begin
    id_d = id_q;
    if (id_sel && state == S_CAP_DR)     id_d = ID_INIT;
    else if (id_sel && state == S_SH_DR) id_d = {tdi, id_q[ID_W-1:1]};
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      byp_q <= 1'b0;
      id_q  <= ID_INIT;
    end else begin
      byp_q <= byp_d;
      id_q  <= id_d;
    end
  end

  always_comb begin
    if (bsr_sel)     dr_so = bsr_so;
    else if (id_sel) dr_so = id_q[0];
    else             dr_so = byp_q;
  end

  assert_bypass_cap_R5: assert property (@(posedge tck) disable iff (!rst_n)
    (byp_sel && state == S_CAP_DR) |=> (byp_q == 1'b0));

  assert_id_cap_R6: assert property (@(posedge tck) disable iff (!rst_n)
    (id_sel && state == S_CAP_DR) |=> (id_q == ID_INIT));

endmodule

// File: rtl/tap_ctrl.sv
module tap_ctrl
  import tap_pkg::*;
#(
  parameter int          SYNC_STAGES = 2,
  parameter int          ID_W        = 32,
  parameter logic [31:0] ID_VALUE    = 32'h05B0503F
) (
  input  logic tck,
  input  logic tms,
  input  logic tdi,
  input  logic trst_n,
  input  logic comp_en,
  output logic tdo,
  output logic tdo_oe,
  output logic mode_extest,
  output logic mode_sample,
  output logic mode_highz,
  output logic bsr_capture,
  output logic bsr_shift,
  output logic bsr_update,
  output logic bsr_si,
  input  logic bsr_so
);

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_n;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_n = rst_sync_q[SYNC_STAGES-1];

  tap_state_t state;
  instr_t     instr;
  logic       ir_so, dr_so, bsr_sel;
  logic       tdo_d, oe_d, tdo_q, oe_q;

  tap_fsm #(.RESET_RUN(5)) i_fsm (
    .tck(tck), .rst_n(rst_n), .comp_en(comp_en), .tms(tms), .state(state)
  );

  tap_ir i_ir (
    .tck(tck), .rst_n(rst_n), .state(state), .tdi(tdi),
    .ir_so(ir_so), .instr(instr)
  );

  tap_dr #(.ID_W(ID_W), .ID_VALUE(ID_VALUE)) i_dr (
    .tck(tck), .rst_n(rst_n), .state(state), .instr(instr), .tdi(tdi),
    .bsr_so(bsr_so), .bsr_sel(bsr_sel), .dr_so(dr_so)
  );

  always_comb begin
    oe_d  = comp_en && (state == S_SH_IR || state == S_SH_DR);
    tdo_d = (state == S_SH_IR) ? ir_so : dr_so;
  end

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) begin
      tdo_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      tdo_q <= tdo_d;
      oe_q  <= oe_d;
    end
  end

  assign tdo         = tdo_q;
  assign tdo_oe      = oe_q && comp_en;
  assign mode_extest = comp_en && (instr == K_EXTEST);
  assign mode_sample = comp_en && (instr == K_SAMPLE);
  assign mode_highz  = comp_en && (instr == K_HIGHZ);
  assign bsr_capture = comp_en && bsr_sel && (state == S_CAP_DR);
  assign bsr_shift   = comp_en && bsr_sel && (state == S_SH_DR);
  assign bsr_update  = comp_en && bsr_sel && (state == S_UPD_DR);
  assign bsr_si      = tdi;

  assert_mode_onehot_R4: assert property (@(posedge tck) disable iff (!rst_n)
    $onehot0({mode_extest, mode_sample, mode_highz}));

  assert_oe_shift_R9: assert property (@(posedge tck) disable iff (!rst_n)
    tdo_oe |-> (state == S_SH_IR || state == S_SH_DR));

  assert_strobe_sel_R7: assert property (@(posedge tck) disable iff (!rst_n)
    (bsr_capture || bsr_shift || bsr_update) |-> (mode_extest || mode_sample));

endmodule

// File: tb/test_tap_ctrl.sv
module test_tap_ctrl;

  localparam logic [31:0] IDV = 32'h05B0503F;
  localparam int NBITS = 40;

  logic tck = 1'b0;
  logic tms = 1'b1, tdi = 1'b0, trst_n = 1'b0, comp_en = 1'b1;
  logic tdo, tdo_oe, mode_extest, mode_sample, mode_highz;
  logic bsr_capture, bsr_shift, bsr_update, bsr_si, bsr_so;
  logic [3:0] bmodel;

  int total = 0, bad = 0;
  int n_cap, n_sh, n_upd, n_oe, n_glitch;
  logic last_tdo, last_oe;
  bit done = 0;

  always #4 tck = ~tck;

  tap_ctrl i_tap_ctrl (
    .tck(tck), .tms(tms), .tdi(tdi), .trst_n(trst_n), .comp_en(comp_en),
    .tdo(tdo), .tdo_oe(tdo_oe), .mode_extest(mode_extest),
    .mode_sample(mode_sample), .mode_highz(mode_highz),
    .bsr_capture(bsr_capture), .bsr_shift(bsr_shift), .bsr_update(bsr_update),
    .bsr_si(bsr_si), .bsr_so(bsr_so)
  );

  always @(posedge tck) begin
    if (bsr_capture)    bmodel <= 4'b1010;
    else if (bsr_shift) bmodel <= {bsr_si, bmodel[3:1]};
  end
  assign bsr_so = bmodel[0];

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d);
    @(negedge tck); #1;
    tms = m; tdi = d; #1;
    last_tdo = tdo; last_oe = tdo_oe;
    n_cap += int'(bsr_capture); n_sh += int'(bsr_shift);
    n_upd += int'(bsr_update);  n_oe += int'(tdo_oe);
    @(posedge tck); #1;
    if (tdo !== last_tdo) n_glitch++;
  endtask

  task automatic clr();
    n_cap = 0; n_sh = 0; n_upd = 0; n_oe = 0;
  endtask

  task automatic ir_scan(input logic [2:0] op, output logic [2:0] got);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    for (int k = 0; k < 3; k++) begin
      step(k == 2, op[k]);
      got[k] = last_tdo;
    end
    step(1, 0); step(0, 0);
  endtask

  task automatic dr_scan(input logic [63:0] p, output logic [63:0] got);
    got = '0;
    clr();
    step(1, 0); step(0, 0); step(0, 0);
    for (int k = 0; k < NBITS; k++) begin
      step(k == NBITS - 1, p[k]);
      got[k] = last_tdo;
    end
    step(1, 0); step(0, 0);
  endtask

  // kind: 0 boundary, 1 identify, 2 bypass
  function automatic logic [63:0] exp_scan(input int kind, input logic [63:0] p);
    logic [63:0] e = '0;
    for (int k = 0; k < NBITS; k++) begin
      if (kind == 0)      e[k] = (k < 4)  ? ((4'b1010 >> k) & 1'b1) : p[k-4];
      else if (kind == 1) e[k] = (k < 32) ? IDV[k] : p[k-32];
      else                e[k] = (k < 1)  ? 1'b0 : p[k-1];
    end
    return e;
  endfunction

  initial begin
    #1500000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] got, p;
    logic [2:0] irg;
    n_glitch = 0;
    clr();
    #20;
    chk(!tdo_oe && !mode_extest && !mode_sample && !mode_highz &&
        !bsr_capture && !bsr_shift && !bsr_update, "R1 reset outputs",
        {tdo_oe, mode_extest, mode_sample, mode_highz}, 0);
    trst_n = 1'b1;
    step(1, 0); step(1, 0); step(1, 0); step(0, 0);

    dr_scan(64'h00A5_1234_5678_9ABC, got);
    chk(got[NBITS-1:0] == exp_scan(1, 64'h00A5_1234_5678_9ABC), "R6 identify after reset",
        got, exp_scan(1, 64'h00A5_1234_5678_9ABC));
    chk(n_oe == NBITS, "R9 oe during shift only", n_oe, NBITS);
    #1;
    chk(!tdo_oe, "R9 oe low in idle", tdo_oe, 0);

    ir_scan(3'b111, irg);
    chk(irg == 3'b001, "R3 instruction capture", irg, 3'b001);

    for (int op = 0; op < 8; op++) begin
      int kind;
      logic ex, sa, hz;
      ex = (op == 0 || op == 3); sa = (op == 1); hz = (op == 4 || op == 6);
      kind = (ex || sa) ? 0 : (op == 2) ? 1 : 2;
      ir_scan(3'(op), irg);
      chk({mode_extest, mode_sample, mode_highz} == {ex, sa, hz}, "R4 decode",
          {mode_extest, mode_sample, mode_highz}, {ex, sa, hz});
      p = 64'h0000_C3A5_96E1_0F2D ^ (64'(op) * 64'h0000_1111_0101_3579);
      dr_scan(p, got);
      chk(got[NBITS-1:0] == exp_scan(kind, p),
          kind == 0 ? "R7 boundary path" : kind == 1 ? "R6 identify path" : "R5 bypass path",
          got, exp_scan(kind, p));
      if (kind == 0)
        chk(n_cap == 1 && n_sh == NBITS && n_upd == 1, "R7 strobe counts",
            n_sh, NBITS);
      else
        chk(n_cap == 0 && n_sh == 0 && n_upd == 0, "R7 strobes idle",
            n_cap + n_sh + n_upd, 0);
      if (hz) chk(mode_highz, "R8 pins-off persists after scan", mode_highz, 1);
    end

    ir_scan(3'b100, irg);
    step(1, 0); step(0, 0); step(0, 0);
    step(1, 0); step(1, 0); step(1, 0); step(1, 0);
    chk(mode_highz, "R2 four ones not enough / R8 held", mode_highz, 1);
    step(1, 0); step(0, 0);
    chk(!mode_highz, "R2 five ones reach reset", mode_highz, 0);
    dr_scan(64'h0000_00FF_00FF_00FF, got);
    chk(got[NBITS-1:0] == exp_scan(1, 64'h0000_00FF_00FF_00FF), "R2 identify after five ones",
        got, exp_scan(1, 64'h0000_00FF_00FF_00FF));

    ir_scan(3'b011, irg);
    chk(mode_extest, "R4 alternate boundary-drive code", mode_extest, 1);
    comp_en = 1'b0; #1;
    chk(!mode_extest && !tdo_oe, "R10 modes off when disabled", mode_extest, 0);
    dr_scan(64'h0, got);
    chk(n_oe == 0 && n_cap == 0 && n_sh == 0 && n_upd == 0, "R10 no drive while disabled",
        n_oe + n_sh, 0);
    comp_en = 1'b1;
    step(0, 0);
    chk(!mode_extest && !mode_sample && !mode_highz, "R10 identify after enable",
        {mode_extest, mode_sample, mode_highz}, 0);
    dr_scan(64'h0000_0055_AA55_AA55, got);
    chk(got[NBITS-1:0] == exp_scan(1, 64'h0000_0055_AA55_AA55), "R10 identify path after enable",
        got, exp_scan(1, 64'h0000_0055_AA55_AA55));

    ir_scan(3'b001, irg);
    step(1, 0); step(0, 0); step(0, 0); step(0, 1); step(0, 0);
    #1 trst_n = 1'b0; #1;
    chk(!mode_sample && !tdo_oe && !bsr_shift, "R1 async reset mid-scan",
        {mode_sample, tdo_oe, bsr_shift}, 0);
    #20 trst_n = 1'b1;
    step(0, 0); step(0, 0); step(0, 0);
    dr_scan(64'h0000_0012_3456_789A, got);
    chk(got[NBITS-1:0] == exp_scan(1, 64'h0000_0012_3456_789A), "R1 identify after async reset",
        got, exp_scan(1, 64'h0000_0012_3456_789A));

    chk(n_glitch == 0, "R9 tdo stable across rising edges", n_glitch, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule